// File: doc/BRIEF.md
# Lamp Ignition and Protection Sequencer

This block is the digital control core of a cold-cathode lamp inverter. It walks the bridge through four phases: idle, ignition, regulated running and a latched trip. It acts on one enable level and two comparator flags. One flag reports output over-voltage and the other reports that lamp current is flowing. A programmable tick count sets the longest time allowed for ignition. The analog loop, the comparators and the oscillator sit outside. They consume the block's outputs: a bridge enable, a select for the higher strike frequency, a command to freeze the drive level, a soft-start reset and a fault indication with a cause code.

The block separates two failures. If no lamp current appears within the ignition window, the lamp is taken to be open at power-up, and the block trips with a timeout cause. If current vanishes after the lamp has been running, the lamp is taken to have been removed, and the block trips on the next decision edge with a removal cause. Both trips ignore the enable input. Only the chip reset clears them. Both comparator flags cross into the clock domain through a two-flop synchronizer. Reset is applied asynchronously and released through a two-flop chain.

Top module: `lamp_ignition_seq`

## Requirements
- R1: While `rst_n` is low, and after it, the outputs show the idle state: bridge, strike select, hold and fault are low, soft-start reset is high and `fault_kind_o` is 2'b00. Internal reset ends on the second rising clock edge after `rst_n` rises, and the third edge is the first that can change state.
- R2: From idle, `enable_i` high at a decision edge starts ignition at that edge. `enable_i` low at a decision edge during ignition or running returns the block to idle. `bridge_en_o` is high exactly during ignition and running.
- R3: `strike_sel_o` is high exactly during ignition. It is low during running, so the bridge returns to the operating frequency.
- R4: `hold_drive_o` equals the synchronized over-voltage flag during ignition and is low in every other state.
- R5: If the synchronized lamp flag stays low, ignition lasts max(`strike_ticks_i`,1) clock cycles, with the tick value sampled on each edge. The block then trips with `fault_kind_o` = 2'b01.
- R6: The synchronized lamp flag during ignition moves the block to running at that edge, and it wins over a timeout in the same cycle. The ignition timer is held at zero outside ignition, so each new ignition gets a full window.
- R7: In running with enable high, a low synchronized lamp flag trips the block on that edge, with `fault_kind_o` = 2'b10.
- R8: In the trip state the bridge, strike select and hold are low and `fault_o` is high. The state and its cause stay fixed whatever `enable_i` does, until `rst_n` is asserted.
- R9: `ss_reset_o` is high in idle and trip, and low in ignition and running, so the soft ramp starts at ignition and runs on into running.
- R10: Each raw flag passes through two flops. A change at the raw input appears at `hold_drive_o` after the second rising edge and steers a state decision on the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enable_i | input | 1 | Run request level |
| ovp_raw_i | input | 1 | Asynchronous over-voltage comparator flag |
| lamp_raw_i | input | 1 | Asynchronous lamp-current-present flag |
| strike_ticks_i | input | TICK_W | Ignition window length in clock cycles |
| bridge_en_o | output | 1 | Bridge switching enable |
| strike_sel_o | output | 1 | Selects the strike frequency |
| hold_drive_o | output | 1 | Freeze the drive level (voltage limit reached) |
| ss_reset_o | output | 1 | Holds the soft-start ramp at zero |
| fault_o | output | 1 | Latched trip |
| fault_kind_o | output | 2 | Trip cause: 00 none, 01 ignition timeout, 10 lamp removed |

## Verification
The enable input and the tick count act on the next rising edge. Their effect on the outputs can be seen just after that edge, because all outputs decode the state register with no further flop. A raw flag change shows at the hold output one edge later than that, and it affects a state transition two edges later. The bench drives inputs at the falling edge and samples 1 ns after each rising edge. It advances a cycle model that carries the same two-stage flag delay and the two-edge reset release, and it compares every output on every cycle. Directed sequences also check the three-edge lamp latency, the exact timeout cycle and the removal trip against literal expected values.

// File: rtl/lampseq_pkg.sv
package lampseq_pkg;

  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_IGNITE = 2'd1,
    ST_RUN    = 2'd2,
    ST_TRIP   = 2'd3
  } seq_state_t;

  typedef enum logic [1:0] {
    FLT_NONE      = 2'b00,
    FLT_NO_STRIKE = 2'b01,
    FLT_LAMP_LOST = 2'b10
  } fault_code_t;

endpackage

// File: rtl/lampseq_rst_sync.sv
module lampseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/lampseq_flag_sync.sv
module lampseq_flag_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/lampseq_ign_timer.sv
module lampseq_ign_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [TW-1:0] limit_i,
  output logic          expired_o
);

  localparam int XW = TW + 1;
  localparam logic [TW-1:0] CNT_MAX = '1;

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    if (!run_i)                cnt_d = '0;
    else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
    else                       cnt_d = cnt_q + 1'b1;
  end

  assign cnt_en = run_i || (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = ({1'b0, cnt_q} + XW'(1)) >= {1'b0, limit_i};

  AST_TIMER_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0)); // R6

  AST_TIMER_STEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R5

endmodule

// File: rtl/lamp_ignition_seq.sv
module lamp_ignition_seq
  import lampseq_pkg::*;
#(
  parameter int TICK_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic              ovp_raw_i,
  input  logic              lamp_raw_i,
  input  logic [TICK_W-1:0] strike_ticks_i,
  output logic              bridge_en_o,
  output logic              strike_sel_o,
  output logic              hold_drive_o,
  output logic              ss_reset_o,
  output logic              fault_o,
  output logic [1:0]        fault_kind_o
);

  logic        rst_int_n;
  logic [1:0]  flags_s;
  logic        ovp_s, lamp_s;
  logic        win_expired;
  seq_state_t  state_q, state_d;
  fault_code_t kind_q, kind_d;
  logic        state_en;

  lampseq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .rst_no (rst_int_n)
  );

  lampseq_flag_sync #(.W(2), .STAGES(SYNC_STAGES)) u_flag_sync (
    .clk_i  (clk),
    .rst_ni (rst_int_n),
    .d_i    ({ovp_raw_i, lamp_raw_i}),
    .q_o    (flags_s)
  );

  assign ovp_s  = flags_s[1];
  assign lamp_s = flags_s[0];

  lampseq_ign_timer #(.TW(TICK_W)) u_ign_timer (
    .clk_i     (clk),
    .rst_ni    (rst_int_n),
    .run_i     (state_q == ST_IGNITE),
    .limit_i   (strike_ticks_i),
    .expired_o (win_expired)
  );

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    unique case (state_q)
      ST_OFF: begin
        if (enable_i) state_d = ST_IGNITE;
      end
      ST_IGNITE: begin
        if (!enable_i) begin
          state_d = ST_OFF;
        end else if (lamp_s) begin
          state_d = ST_RUN;
        end else if (win_expired) begin
          state_d = ST_TRIP;
          kind_d  = FLT_NO_STRIKE;
        end
      end
      ST_RUN: begin
        if (!enable_i) begin
          state_d = ST_OFF;
        end else if (!lamp_s) begin
          state_d = ST_TRIP;
          kind_d  = FLT_LAMP_LOST;
        end
      end
      ST_TRIP: begin
        state_d = ST_TRIP;
      end
      default: state_d = ST_OFF;
    endcase
  end

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_OFF;
      kind_q  <= FLT_NONE;
    end else if (state_en) begin
      state_q <= state_d;
      kind_q  <= kind_d;
    end
  end

  assign bridge_en_o  = (state_q == ST_IGNITE) || (state_q == ST_RUN);
  assign strike_sel_o = (state_q == ST_IGNITE);
  assign hold_drive_o = (state_q == ST_IGNITE) && ovp_s;
  assign ss_reset_o   = (state_q == ST_OFF) || (state_q == ST_TRIP);
  assign fault_o      = (state_q == ST_TRIP);
  assign fault_kind_o = kind_q;

  AST_STRIKE_IMPLIES_DRIVE: assert property (@(posedge clk) disable iff (!rst_int_n)
    strike_sel_o |-> bridge_en_o); // R3

  AST_HOLD_ONLY_IGNITING: assert property (@(posedge clk) disable iff (!rst_int_n)
    hold_drive_o |-> strike_sel_o); // R4

  AST_TRIP_SILENT: assert property (@(posedge clk) disable iff (!rst_int_n)
    fault_o |-> (!bridge_en_o && ss_reset_o)); // R8

  AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (!rst_int_n)
    fault_o |=> (fault_o && $stable(fault_kind_o))); // R8

  AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bridge_en_o && !enable_i) |=> !bridge_en_o); // R2

  AST_LAMP_LOSS_TRIPS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_RUN && enable_i && !lamp_s) |=> (fault_kind_o == FLT_LAMP_LOST)); // R7

  AST_KIND_CLEAN: assert property (@(posedge clk) disable iff (!rst_int_n)
    !fault_o |-> (fault_kind_o == 2'b00)); // R1

endmodule

// File: tb/lamp_ignition_seq_bench.sv
module lamp_ignition_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TW         = 16;

  logic          clk;
  logic          rst_n;
  logic          enable_i, ovp_raw_i, lamp_raw_i;
  logic [TW-1:0] strike_ticks_i;
  logic          bridge_en_o, strike_sel_o, hold_drive_o, ss_reset_o, fault_o;
  logic [1:0]    fault_kind_o;

  int tests_run = 0;
  int tests_failed = 0;
  bit finished = 0;

  // cycle model state: 0 idle, 1 ignition, 2 running, 3 trip
  int         m_st, m_cnt, m_rel;
  logic [1:0] m_kind;
  logic       m_o1, m_o2, m_l1, m_l2;

  lamp_ignition_seq #(.TICK_W(TW), .SYNC_STAGES(2)) u_lamp_ignition_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .enable_i       (enable_i),
    .ovp_raw_i      (ovp_raw_i),
    .lamp_raw_i     (lamp_raw_i),
    .strike_ticks_i (strike_ticks_i),
    .bridge_en_o    (bridge_en_o),
    .strike_sel_o   (strike_sel_o),
    .hold_drive_o   (hold_drive_o),
    .ss_reset_o     (ss_reset_o),
    .fault_o        (fault_o),
    .fault_kind_o   (fault_kind_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    tests_run++;
    if (act != exp) begin
      tests_failed++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic timeout_due(int cnt, int lim);
    return (cnt + 1) >= lim;
  endfunction

  function automatic string kind_tag(logic [1:0] k);
    if (k == 2'b01) return "R5";
    if (k == 2'b10) return "R7";
    return "R1";
  endfunction

  task automatic model_reset();
    m_st = 0; m_cnt = 0; m_rel = 0; m_kind = 2'b00;
    m_o1 = 0; m_o2 = 0; m_l1 = 0; m_l2 = 0;
  endtask

  task automatic model_edge();
    bit active;
    int nst;
    active = (m_rel == 2) && rst_n;
    if (rst_n && m_rel < 2) m_rel++;
    if (active) begin
      nst = m_st;
      case (m_st)
        0: if (enable_i) nst = 1;
        1: begin
          if (!enable_i) nst = 0;
          else if (m_l2) nst = 2;
          else if (timeout_due(m_cnt, int'(strike_ticks_i))) begin nst = 3; m_kind = 2'b01; end
        end
        2: begin
          if (!enable_i) nst = 0;
          else if (!m_l2) begin nst = 3; m_kind = 2'b10; end
        end
        default: nst = 3;
      endcase
      m_cnt = (m_st == 1) ? m_cnt + 1 : 0;
      m_st  = nst;
      m_o2 = m_o1; m_o1 = ovp_raw_i;
      m_l2 = m_l1; m_l1 = lamp_raw_i;
    end
  endtask

  task automatic compare_all();
    chk("R2 bridge_en", bridge_en_o, (m_st == 1 || m_st == 2));
    chk("R3 strike_sel", strike_sel_o, (m_st == 1));
    chk("R4 hold_drive", hold_drive_o, (m_st == 1) && m_o2);
    chk("R9 ss_reset", ss_reset_o, (m_st == 0 || m_st == 3));
    chk("R8 fault", fault_o, (m_st == 3));
    chk({kind_tag(m_kind), " fault_kind"}, fault_kind_o, m_kind);
  endtask

  // one clock cycle: inputs are set by caller before, applied at falling edge
  task automatic tick(input logic en, input logic ovp, input logic lamp,
                      input logic [TW-1:0] tk, input logic rn);
    @(negedge clk);
    enable_i = en; ovp_raw_i = ovp; lamp_raw_i = lamp; strike_ticks_i = tk; rst_n = rn;
    if (!rn) model_reset();
    #1;
    if (!rn) compare_all();
    @(posedge clk);
    model_edge();
    #1;
    compare_all();
  endtask

  task automatic do_reset();
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 1'b0, 16'd8, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 16'd8, 1'b1);
    tick(1'b0, 1'b0, 1'b0, 16'd8, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    logic en, ovp, lamp, rn;
    logic [TW-1:0] tk;
    seed_dummy = $urandom(32'd20240611);
    enable_i = 0; ovp_raw_i = 0; lamp_raw_i = 0; strike_ticks_i = 16'd8; rst_n = 0;
    model_reset();

    // R1: reset state
    do_reset();
    chk("R1 idle soft-start reset", ss_reset_o, 1);
    chk("R1 idle kind", fault_kind_o, 0);

    // R5: open lamp, window of 5 cycles
    tick(1'b1, 1'b0, 1'b0, 16'd5, 1'b1);
    chk("R2 ignition starts", strike_sel_o, 1);
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b0, 1'b0, 16'd5, 1'b1);
    chk("R5 still igniting at cycle 5", strike_sel_o, 1);
    tick(1'b1, 1'b0, 1'b0, 16'd5, 1'b1);
    chk("R5 timeout kind", fault_kind_o, 1);

    // R8: enable toggling leaves the trip in place
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 1'b0, 16'd5, 1'b1);
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 1'b1, 16'd5, 1'b1);
    chk("R8 trip survives enable", fault_o, 1);
    chk("R8 trip keeps bridge off", bridge_en_o, 0);

    // R6 / R10: lamp present at ignition, three-edge latency
    do_reset();
    tick(1'b1, 1'b0, 1'b1, 16'd100, 1'b1);
    chk("R10 lamp not yet seen e1", strike_sel_o, 1);
    tick(1'b1, 1'b0, 1'b1, 16'd100, 1'b1);
    chk("R10 lamp not yet seen e2", strike_sel_o, 1);
    tick(1'b1, 1'b0, 1'b1, 16'd100, 1'b1);
    chk("R6 running strike off", strike_sel_o, 0);
    chk("R6 running bridge on", bridge_en_o, 1);
    for (int i = 0; i < 20; i++) tick(1'b1, 1'b0, 1'b1, 16'd3, 1'b1);

    // R7: lamp removed while running
    tick(1'b1, 1'b0, 1'b0, 16'd3, 1'b1);
    tick(1'b1, 1'b0, 1'b0, 16'd3, 1'b1);
    chk("R10 removal not yet seen", bridge_en_o, 1);
    tick(1'b1, 1'b0, 1'b0, 16'd3, 1'b1);
    chk("R7 removal kind", fault_kind_o, 2);
    chk("R7 removal drive off", bridge_en_o, 0);

    // R4 / R10: over-voltage hold latency
    do_reset();
    tick(1'b1, 1'b1, 1'b0, 16'd50, 1'b1);
    chk("R10 hold not yet e1", hold_drive_o, 0);
    tick(1'b1, 1'b1, 1'b0, 16'd50, 1'b1);
    chk("R4 hold after e2", hold_drive_o, 1);
    tick(1'b1, 1'b0, 1'b0, 16'd50, 1'b1);
    tick(1'b1, 1'b0, 1'b0, 16'd50, 1'b1);
    chk("R4 hold released", hold_drive_o, 0);

    // R6: disable and re-enable gives a fresh full window
    tick(1'b0, 1'b0, 1'b0, 16'd4, 1'b1);
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b0, 1'b0, 16'd4, 1'b1);
    chk("R6 fresh window still igniting", strike_sel_o, 1);
    tick(1'b1, 1'b0, 1'b0, 16'd4, 1'b1);
    chk("R6 fresh window then timeout", fault_kind_o, 1);

    // R5: zero ticks behaves as one
    do_reset();
    tick(1'b1, 1'b0, 1'b0, 16'd0, 1'b1);
    tick(1'b1, 1'b0, 1'b0, 16'd0, 1'b1);
    chk("R5 zero window trips", fault_kind_o, 1);

    // random traffic against the cycle model
    do_reset();
    en = 1; lamp = 0; tk = 16'd6;
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 99) < 6) en = ~en;
      if ($urandom_range(0, 99) < 8) lamp = ~lamp;
      ovp = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 99) < 3) tk = TW'($urandom_range(0, 14));
      rn = ($urandom_range(0, 199) != 0);
      tick(en, ovp, lamp, tk, rn);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule